// File: doc/BRIEF.md
# SPI Command Response Checker

After a host has shifted a command packet onto the SPI bus, this block decides whether the target accepted it. On a start pulse it latches the opcode that was sent. It then pulls response bytes from the SPI byte stream one at a time through a request/valid handshake. Each pulled byte is one attempt.

The block hunts in two stages. The first stage looks for a byte that repeats the opcode. The second stage looks for a zero status byte. Each stage has its own bounded number of attempts. When the reset opcode fails either stage, the block does not report failure at once. It enters a recovery phase instead: it drives 0xFF filler bytes onto the transmit side and reads a fixed number of bytes back. Whether the last of those bytes is 0xFF decides the verdict.

At the end of every check the block raises `done_o` for one cycle, together with exactly one of `ok_o` or `fail_o`. Building the command packet and moving payload data are handled by other blocks.

Top module: `spi_rsp_check`

## Requirements
- R1: After reset is released, `done_o`, `ok_o`, `fail_o` and `rx_ready_o` are low and `tx_data_o` is 0x00.
- R2: `start_i` is honoured only while the block is idle. It latches `opcode_i`, and `rx_ready_o` goes high in the next cycle. A `start_i` pulse during a check has no effect on that check's outcome.
- R3: In the echo stage, each byte taken (`rx_valid_i` and `rx_ready_o` both high at a clock edge) counts as one attempt. The first byte equal to the latched opcode moves the block to the status stage.
- R4: If `RETRIES` (default 10) echo attempts pass without a match, the check ends with failure, unless the opcode is the reset opcode.
- R5: In the status stage, the first taken byte equal to 0x00 ends the check with success. This holds even on the last allowed attempt.
- R6: If `RETRIES` status attempts pass without a 0x00 byte, the check ends with failure, unless the opcode is the reset opcode.
- R7: When the reset opcode (`RESET_OP`, default 0xCF) exhausts either stage, the block enters recovery. While in recovery, `tx_data_o` is 0xFF; at all other times it is 0x00.
- R8: Recovery takes exactly `FILL_LEN` (default 8) bytes. The check succeeds if the last of them is 0xFF and fails otherwise.
- R9: `done_o` is high for exactly one cycle, in the cycle after the edge that took the deciding byte. Exactly one of `ok_o` and `fail_o` is high with it, and both are low whenever `done_o` is low.
- R10: While idle, `rx_ready_o` is low and bytes offered on `rx_valid_i` are not taken and do not change any output.
- R11: The reset opcode that passes both stages ends with success without entering recovery.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a check (honoured when idle) |
| opcode_i | input | 8 | Opcode that was sent |
| rx_data_i | input | 8 | Received response byte |
| rx_valid_i | input | 1 | Received byte present |
| rx_ready_o | output | 1 | Block requests a byte |
| tx_data_o | output | 8 | Byte to shift out while reading (0xFF in recovery) |
| done_o | output | 1 | One-cycle end-of-check pulse |
| ok_o | output | 1 | Check succeeded, with done_o |
| fail_o | output | 1 | Check failed, with done_o |

## Verification
The bench places the echo and the zero status exactly on the tenth attempt. An off-by-one in an attempt counter would turn these passes into failures, or let an eleventh byte be taken. The reset opcode is driven through both stage exhaustions and through recovery runs ending in 0xFF and in 0x00. A design that failed immediately, read the wrong number of filler bytes, or judged a byte other than the last one would give the wrong verdict. A second start during a hunt, and bytes offered while idle, would corrupt the latched opcode or be consumed if the design did not gate them. Every cycle is also compared against a behavioural model, so a late or stretched `done_o` is caught as well.

// File: rtl/spi_rsp_pkg.sv
package spi_rsp_pkg;
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_ECHO  = 2'd1,
    PH_STAT  = 2'd2,
    PH_RECOV = 2'd3
  } phase_e;

  localparam logic [7:0] FILL_BYTE = 8'hFF;
  localparam logic [7:0] STAT_OK   = 8'h00;
endpackage

// File: rtl/spi_rsp_tally.sv
module spi_rsp_tally #(
  parameter int LIMIT = 10,
  localparam int CW = (LIMIT < 2) ? 1 : $clog2(LIMIT)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic inc_i,
  output logic last_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clr_i)   cnt_q <= '0;
    else if (inc_i)   cnt_q <= cnt_q + 1'b1;
  end

  assign last_o = (cnt_q == CW'(LIMIT - 1));

  // attempts never run past the budget (R4, R6, R8)
  assert_tally_bound_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(cnt_q) < LIMIT);
  assert_tally_no_wrap_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (last_o && !clr_i) |-> !inc_i);
endmodule

// File: rtl/spi_rsp_match.sv
module spi_rsp_match
  import spi_rsp_pkg::*;
(
  input  phase_e     phase_i,
  input  logic [7:0] op_i,
  input  logic [7:0] byte_i,
  output logic       hit_o
);
  logic [7:0] want;

  always_comb begin
    unique case (phase_i)
      PH_ECHO:  want = op_i;
      PH_STAT:  want = STAT_OK;
      PH_RECOV: want = FILL_BYTE;
      default:  want = 8'h00;
    endcase
  end

  assign hit_o = (phase_i != PH_IDLE) && (byte_i == want);
endmodule

// File: rtl/spi_rsp_fsm.sv
module spi_rsp_fsm
  import spi_rsp_pkg::*;
#(
  parameter logic [7:0] RESET_OP = 8'hCF
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic [7:0] opcode_i,
  input  logic       take_i,
  input  logic       hit_i,
  input  logic       hunt_last_i,
  input  logic       fill_last_i,
  output phase_e     phase_o,
  output logic [7:0] op_o,
  output logic       hunt_clr_o,
  output logic       hunt_inc_o,
  output logic       fill_clr_o,
  output logic       fill_inc_o,
  output logic       done_o,
  output logic       ok_o,
  output logic       fail_o
);
  phase_e     ph_q, ph_d;
  logic [7:0] op_q;
  logic       done_d, ok_d, fail_d;
  logic       is_rst_op;

  assign is_rst_op = (op_q == RESET_OP);

  always_comb begin
    ph_d       = ph_q;
    done_d     = 1'b0;
    ok_d       = 1'b0;
    fail_d     = 1'b0;
    hunt_clr_o = 1'b0;
    hunt_inc_o = 1'b0;
    fill_clr_o = 1'b0;
    fill_inc_o = 1'b0;
    unique case (ph_q)
      PH_IDLE: if (start_i) begin
        ph_d       = PH_ECHO;
        hunt_clr_o = 1'b1;
      end
      PH_ECHO, PH_STAT: if (take_i) begin
        if (hit_i) begin
          hunt_clr_o = 1'b1;
          if (ph_q == PH_ECHO) ph_d = PH_STAT;
          else begin
            ph_d = PH_IDLE; done_d = 1'b1; ok_d = 1'b1;
          end
        end else if (hunt_last_i) begin
          hunt_clr_o = 1'b1;
          if (is_rst_op) begin
            ph_d       = PH_RECOV;
            fill_clr_o = 1'b1;
          end else begin
            ph_d = PH_IDLE; done_d = 1'b1; fail_d = 1'b1;
          end
        end else begin
          hunt_inc_o = 1'b1;
        end
      end
      PH_RECOV: if (take_i) begin
        if (fill_last_i) begin
          ph_d   = PH_IDLE;
          done_d = 1'b1;
          ok_d   = hit_i;
          fail_d = !hit_i;
        end else begin
          fill_inc_o = 1'b1;
        end
      end
      default: ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q   <= PH_IDLE;
      op_q   <= 8'h00;
      done_o <= 1'b0;
      ok_o   <= 1'b0;
      fail_o <= 1'b0;
    end else begin
      ph_q   <= ph_d;
      done_o <= done_d;
      ok_o   <= ok_d;
      fail_o <= fail_d;
      if (ph_q == PH_IDLE && start_i) op_q <= opcode_i;
    end
  end

  assign phase_o = ph_q;
  assign op_o    = op_q;

  // opcode stays latched through a check (R2)
  assert_op_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ph_q != PH_IDLE) |=> $stable(op_q));
  // recovery only for the reset opcode (R7)
  assert_recov_only_rst_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ph_q == PH_RECOV) |-> is_rst_op);
endmodule

// File: rtl/spi_rsp_check.sv
module spi_rsp_check
  import spi_rsp_pkg::*;
#(
  parameter int         RETRIES  = 10,
  parameter int         FILL_LEN = 8,
  parameter logic [7:0] RESET_OP = 8'hCF
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic [7:0] opcode_i,
  input  logic [7:0] rx_data_i,
  input  logic       rx_valid_i,
  output logic       rx_ready_o,
  output logic [7:0] tx_data_o,
  output logic       done_o,
  output logic       ok_o,
  output logic       fail_o
);
  phase_e     phase;
  logic [7:0] op;
  logic       take, hit;
  logic       hunt_clr, hunt_inc, hunt_last;
  logic       fill_clr, fill_inc, fill_last;

  assign rx_ready_o = (phase != PH_IDLE);
  assign tx_data_o  = (phase == PH_RECOV) ? FILL_BYTE : 8'h00;
  assign take       = rx_ready_o && rx_valid_i;

  spi_rsp_match u_match (
    .phase_i (phase),
    .op_i    (op),
    .byte_i  (rx_data_i),
    .hit_o   (hit)
  );

  spi_rsp_tally #(.LIMIT(RETRIES)) u_hunt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (hunt_clr),
    .inc_i  (hunt_inc),
    .last_o (hunt_last)
  );

  spi_rsp_tally #(.LIMIT(FILL_LEN)) u_fill (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (fill_clr),
    .inc_i  (fill_inc),
    .last_o (fill_last)
  );

  spi_rsp_fsm #(.RESET_OP(RESET_OP)) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .opcode_i    (opcode_i),
    .take_i      (take),
    .hit_i       (hit),
    .hunt_last_i (hunt_last),
    .fill_last_i (fill_last),
    .phase_o     (phase),
    .op_o        (op),
    .hunt_clr_o  (hunt_clr),
    .hunt_inc_o  (hunt_inc),
    .fill_clr_o  (fill_clr),
    .fill_inc_o  (fill_inc),
    .done_o      (done_o),
    .ok_o        (ok_o),
    .fail_o      (fail_o)
  );

  assert_verdict_onehot_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $onehot({ok_o, fail_o}));
  assert_verdict_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> !(ok_o || fail_o));
  assert_done_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_done_idle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !rx_ready_o);
  assert_fill_while_req_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_data_o == FILL_BYTE) |-> rx_ready_o);
endmodule

// File: tb/sim_spi_rsp_check.sv
module sim_spi_rsp_check;
  localparam int RETRIES  = 10;
  localparam int FILL_LEN = 8;
  localparam logic [7:0] RST_OP = 8'hCF;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [7:0] opcode = 8'h00;
  logic [7:0] rx_data = 8'h00;
  logic rx_valid = 1'b0;
  logic rx_ready, done, ok, fail;
  logic [7:0] tx_data;

  int n_cmp = 0;
  int n_bad = 0;

  always #10 clk = ~clk; // 50 MHz

  spi_rsp_check #(.RETRIES(RETRIES), .FILL_LEN(FILL_LEN), .RESET_OP(RST_OP)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .opcode_i(opcode),
    .rx_data_i(rx_data), .rx_valid_i(rx_valid), .rx_ready_o(rx_ready),
    .tx_data_o(tx_data), .done_o(done), .ok_o(ok), .fail_o(fail)
  );

  // behavioural reference: 0 idle, 1 echo, 2 status, 3 recovery
  int m_ph = 0;
  int m_n = 0;
  logic [7:0] m_op = 8'h00;
  logic e_done = 1'b0, e_ok = 1'b0, e_fail = 1'b0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ph = 0; m_n = 0; m_op = 8'h00;
      e_done = 1'b0; e_ok = 1'b0; e_fail = 1'b0;
    end else begin
      e_done = 1'b0; e_ok = 1'b0; e_fail = 1'b0;
      if (m_ph == 0) begin
        if (start) begin m_op = opcode; m_ph = 1; m_n = 0; end
      end else if (rx_valid) begin
        m_n = m_n + 1;
        if (m_ph == 3) begin
          if (m_n == FILL_LEN) begin
            e_done = 1'b1; e_ok = (rx_data == 8'hFF); e_fail = !e_ok; m_ph = 0;
          end
        end else if ((m_ph == 1 && rx_data == m_op) || (m_ph == 2 && rx_data == 8'h00)) begin
          if (m_ph == 1) begin m_ph = 2; m_n = 0; end
          else begin e_done = 1'b1; e_ok = 1'b1; m_ph = 0; end
        end else if (m_n == RETRIES) begin
          m_n = 0;
          if (m_op == RST_OP) m_ph = 3;
          else begin e_done = 1'b1; e_fail = 1'b1; m_ph = 0; end
        end
      end
    end
  end

  task automatic cmp(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s t=%0t actual=%02h expected=%02h", tag, $time, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    cmp("R2 rx_ready", {7'd0, rx_ready}, {7'd0, m_ph != 0});
    cmp("R7 tx_data", tx_data, (m_ph == 3) ? 8'hFF : 8'h00);
    cmp("R9 done", {7'd0, done}, {7'd0, e_done});
    cmp("R9 ok", {7'd0, ok}, {7'd0, e_ok});
    cmp("R9 fail", {7'd0, fail}, {7'd0, e_fail});
  end

  task automatic kick(input logic [7:0] op);
    @(negedge clk); start = 1'b1; opcode = op;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic put(input logic [7:0] b);
    @(negedge clk); rx_valid = 1'b1; rx_data = b;
    while (!rx_ready) @(negedge clk);
  endtask

  task automatic finish_chk(input string tag, input logic exp_ok);
    bit seen = 1'b0;
    @(negedge clk); rx_valid = 1'b0;
    for (int i = 0; i < 20 && !seen; i++) begin
      if (done) seen = 1'b1; else @(negedge clk);
    end
    cmp({tag, " done seen"}, {7'd0, seen}, 8'd1);
    cmp({tag, " verdict ok"}, {7'd0, ok}, {7'd0, exp_ok});
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL R9 watchdog actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    cmp("R1 ready", {7'd0, rx_ready}, 8'd0);
    cmp("R1 verdict", {5'd0, done, ok, fail}, 8'd0);
    cmp("R1 tx", tx_data, 8'h00);

    // R10 bytes offered while idle are not taken
    rx_valid = 1'b1; rx_data = 8'hC9;
    repeat (4) begin
      @(negedge clk);
      cmp("R10 idle ready", {7'd0, rx_ready}, 8'd0);
      cmp("R10 idle done", {7'd0, done}, 8'd0);
    end
    rx_valid = 1'b0;

    // R3 R5 echo after junk, then zero status
    kick(8'hC9); put(8'h55); put(8'hC9); put(8'h00); finish_chk("R3 R5 basic", 1'b1);

    // R4 echo never arrives
    kick(8'hCA);
    for (int i = 0; i < RETRIES; i++) put(8'h11);
    finish_chk("R4 echo exhausted", 1'b0);

    // R3 echo on last attempt, R6 status never zero
    kick(8'hCA);
    for (int i = 0; i < RETRIES - 1; i++) put(8'h22);
    put(8'hCA);
    for (int i = 0; i < RETRIES; i++) put(8'hFE);
    finish_chk("R6 status exhausted", 1'b0);

    // R5 zero status on last attempt
    kick(8'hCA); put(8'hCA);
    for (int i = 0; i < RETRIES - 1; i++) put(8'h33);
    put(8'h00); finish_chk("R5 status last try", 1'b1);

    // R11 reset opcode passes normally
    kick(RST_OP); put(RST_OP); put(8'h00); finish_chk("R11 reset pass", 1'b1);

    // R7 R8 echo exhaustion -> recovery, last byte 0xFF
    kick(RST_OP);
    for (int i = 0; i < RETRIES; i++) put(8'h44);
    for (int i = 0; i < FILL_LEN - 1; i++) put(8'h00);
    put(8'hFF); finish_chk("R8 recovery ok", 1'b1);

    // R7 R8 status exhaustion -> recovery, last byte not 0xFF
    kick(RST_OP); put(RST_OP);
    for (int i = 0; i < RETRIES; i++) put(8'h66);
    for (int i = 0; i < FILL_LEN - 1; i++) put(8'hFF);
    put(8'h00); finish_chk("R8 recovery fail", 1'b0);

    // R2 start during a hunt is ignored
    kick(8'hC4); put(8'h77);
    @(negedge clk); rx_valid = 1'b0; start = 1'b1; opcode = 8'hC9;
    @(negedge clk); start = 1'b0;
    put(8'hC4); put(8'h00); finish_chk("R2 restart ignored", 1'b1);

    repeat (3) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule